// File: doc/BRIEF.md
# Scheduled Buffer Transfer Sequencer

This block is a small programmable sequencer. It runs a program held in an instruction memory and copies words from a source buffer into a destination buffer. Each copy happens on a clock cycle that is fixed by its position in the program. The engine never stalls, and it issues one instruction per cycle. A strided block move is the one exception: it occupies as many consecutive cycles as it has transfers. Idle time is written into the program as explicit no-ops.

A short handshake runs a program. A pulse on `start` points the engine at instruction 0 and raises `busy`. The engine then fetches through an asynchronous instruction read port, so the word arrives in the same cycle as its address. Reads go to the source buffer, which returns data one cycle later. The write to the destination buffer comes out of an internal pipeline stage, one cycle after its read. When the engine reaches a no-op with operand zero, it drops `busy`, raises `done` and stays parked until the next `start`. The fifteen address and stride registers keep their contents from one run to the next.

Top module: `xfer_engine`

## Requirements
- R1: After reset, `busy`, `done`, `src_re` and `dst_we` are all low.
- R2: When `start` is sampled high on a clock edge, instruction 0 executes in the next cycle. `busy` stays high from that cycle up to and including the cycle of the terminating no-op.
- R3: An instruction word is 22 bits wide, laid out as follows:
  - opcode in bits [21:20]: 0 = no-op, 1 = load-immediate, 2 = single move, 3 = block move;
  - register field A in bits [19:16];
  - register field B in bits [15:12];
  - register field C in bits [11:8];
  - immediate or count in bits [7:0].
- R4: A load-immediate writes the immediate into register A, and the very next instruction sees the new value. Register 0 always reads as zero, and a load into it has no effect.
- R5: A single move reads the source buffer at reg[A]+imm in its own cycle. In the following cycle it writes the returned word to the destination buffer at reg[B]+imm.
- R6: A block move with count k issues k transfers on k consecutive cycles. Transfer n reads at reg[A]+n·reg[C] and writes at reg[B]+n·reg[C]. The next instruction issues right after the last transfer.
- R7: A block move whose count field is 0 performs exactly one transfer, at offset 0.
- R8: A no-op with a nonzero operand takes one cycle and moves on to the next instruction, with no buffer access.
- R9: On a no-op with operand 0, the next cycle shows `busy` low and `done` high. From then on there are no reads or writes until the next `start`.
- R10: A `start` given while `done` is high clears `done` and runs the program again from instruction 0.
- R11: Every buffer address is computed modulo 2^AW, so a sum that overflows wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at instruction 0 |
| busy | output | 1 | Program is executing |
| done | output | 1 | Terminating no-op reached |
| imem_addr | output | PAW | Instruction fetch address (program counter) |
| imem_data | input | 22 | Instruction word at `imem_addr`, same cycle |
| src_re | output | 1 | Source buffer read enable |
| src_addr | output | AW | Source buffer read address |
| src_rdata | input | DW | Source buffer data, one cycle after the read |
| dst_we | output | 1 | Destination buffer write enable |
| dst_addr | output | AW | Destination buffer write address |
| dst_wdata | output | DW | Destination buffer write data |

## Verification
The bench counts cycles from the first executing cycle, t = 0. Its interpreter assigns each instruction one slot, and each block transfer one slot. A read issued in slot t must appear as a destination write exactly at t+1, carrying the source word the bench placed at the expected read address. `busy` is checked high through the halting slot h, and `done` is first checked high at h+1. Every output is sampled on the falling edge of each cycle and compared with the expectation for that exact slot, so a write that comes one cycle early or late is reported as a miscompare.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int REG_IDX_W = 4;
    localparam int NUM_REGS  = 1 << REG_IDX_W;
    localparam int IMM_W     = 8;
    localparam int INSTR_W   = 2 + 3 * REG_IDX_W + IMM_W;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_LDI  = 2'd1,
        OP_MOV  = 2'd2,
        OP_BLK  = 2'd3
    } op_e;

    typedef struct packed {
        op_e                  op;
        logic [REG_IDX_W-1:0] ra;
        logic [REG_IDX_W-1:0] rb;
        logic [REG_IDX_W-1:0] rc;
        logic [IMM_W-1:0]     imm;
    } instr_t;
endpackage

// File: rtl/xfer_regfile.sv
module xfer_regfile
    import xfer_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] waddr,
    input  logic [AW-1:0]        wdata,
    input  logic [REG_IDX_W-1:0] raddr_a,
    input  logic [REG_IDX_W-1:0] raddr_b,
    input  logic [REG_IDX_W-1:0] raddr_c,
    output logic [AW-1:0]        rdata_a,
    output logic [AW-1:0]        rdata_b,
    output logic [AW-1:0]        rdata_c
);
    logic [AW-1:0] r_q [NUM_REGS];
    logic [AW-1:0] r_d [NUM_REGS];

    assign r_d[0] = '0;
    assign r_q[0] = '0;

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            r_d[g] = r_q[g];
            if (we && waddr == REG_IDX_W'(g)) r_d[g] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q[g] <= '0;
            else        r_q[g] <= r_d[g];
        end
    end

    assign rdata_a = r_q[raddr_a];
    assign rdata_b = r_q[raddr_b];
    assign rdata_c = r_q[raddr_c];

    // R4: a load into a nonzero register is visible on the next cycle
    p_load_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0 && raddr_a == waddr) |=> (rdata_a == $past(wdata) || raddr_a != $past(waddr)));

    // R4: register 0 never reads nonzero
    p_reg0_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_b == '0) |-> (rdata_b == '0));
endmodule

// File: rtl/xfer_agu.sv
module xfer_agu
    import xfer_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0]    base_src,
    input  logic [AW-1:0]    base_dst,
    input  logic [IMM_W-1:0] imm,
    input  logic [AW-1:0]    run_off,
    input  logic             use_run_off,
    output logic [AW-1:0]    src_addr,
    output logic [AW-1:0]    dst_addr
);
    logic [AW-1:0] imm_ext;
    logic [AW-1:0] offset;

    if (IMM_W >= AW) begin : g_trunc
        assign imm_ext = imm[AW-1:0];
    end else begin : g_zext
        assign imm_ext = {{(AW-IMM_W){1'b0}}, imm};
    end

    assign offset   = use_run_off ? run_off : imm_ext;
    // R11: sums truncate to AW bits, wrapping modulo the buffer depth
    assign src_addr = base_src + offset;
    assign dst_addr = base_dst + offset;
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int PAW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic [PAW-1:0]     imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic               src_re,
    output logic [AW-1:0]      src_addr,
    input  logic [DW-1:0]      src_rdata,
    output logic               dst_we,
    output logic [AW-1:0]      dst_addr,
    output logic [DW-1:0]      dst_wdata
);
    typedef struct packed {
        logic [PAW-1:0]   pc;
        logic             busy;
        logic             done;
        logic [IMM_W-1:0] cnt;
        logic [AW-1:0]    off;
        logic             wr_vld;
        logic [AW-1:0]    wr_addr;
    } state_t;

    state_t st_q, st_d;
    instr_t ins;

    logic          rf_we;
    logic [AW-1:0] rf_a, rf_b, rf_c;
    logic [AW-1:0] agu_src, agu_dst;
    logic          issue;
    logic          xfer;
    logic [IMM_W-1:0] last_idx;

    assign ins   = instr_t'(imem_data);
    assign issue = st_q.busy && !start;
    assign xfer  = issue && (ins.op == OP_MOV || ins.op == OP_BLK);
    assign rf_we = issue && ins.op == OP_LDI;
    assign last_idx = (ins.imm == '0) ? '0 : ins.imm - 1'b1;

    xfer_regfile #(.AW(AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (ins.ra),
        .wdata   (AW'(ins.imm)),
        .raddr_a (ins.ra),
        .raddr_b (ins.rb),
        .raddr_c (ins.rc),
        .rdata_a (rf_a),
        .rdata_b (rf_b),
        .rdata_c (rf_c)
    );

    xfer_agu #(.AW(AW)) u_agu (
        .base_src    (rf_a),
        .base_dst    (rf_b),
        .imm         (ins.imm),
        .run_off     (st_q.off),
        .use_run_off (ins.op == OP_BLK),
        .src_addr    (agu_src),
        .dst_addr    (agu_dst)
    );

    always_comb begin
        st_d        = st_q;
        st_d.wr_vld = 1'b0;
        if (start) begin
            st_d.pc   = '0;
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
            st_d.cnt  = '0;
            st_d.off  = '0;
        end else if (st_q.busy) begin
            unique case (ins.op)
                OP_NOP: begin
                    if (ins.imm == '0) begin
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.pc = st_q.pc + 1'b1;
                    end
                end
                OP_LDI: st_d.pc = st_q.pc + 1'b1;
                OP_MOV: begin
                    st_d.wr_vld  = 1'b1;
                    st_d.wr_addr = agu_dst;
                    st_d.pc      = st_q.pc + 1'b1;
                end
                OP_BLK: begin
                    st_d.wr_vld  = 1'b1;
                    st_d.wr_addr = agu_dst;
                    if (st_q.cnt == last_idx) begin
                        st_d.cnt = '0;
                        st_d.off = '0;
                        st_d.pc  = st_q.pc + 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                        st_d.off = st_q.off + rf_c;
                    end
                end
                default: st_d.pc = st_q.pc + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign imem_addr = st_q.pc;
    assign src_re    = xfer;
    assign src_addr  = agu_src;
    assign dst_we    = st_q.wr_vld;
    assign dst_addr  = st_q.wr_addr;
    assign dst_wdata = src_rdata;

    // R5: every read is matched by a write on the following cycle
    p_write_follows_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_re |=> dst_we);

    // R5: no write appears without a read one cycle earlier
    p_no_orphan_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> $past(src_re));

    // R9: a parked engine issues no reads
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !src_re);

    // R9: busy and done are never high together
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9: done rises only as busy falls
    p_halt_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    // R6: later transfers of a block step the read address by the stride
    p_block_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ins.op == OP_BLK && st_q.cnt != '0) |->
        (src_addr == AW'($past(src_addr) + rf_c)));
endmodule

// File: tb/sim_xfer_engine.sv
module sim_xfer_engine;
    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam int PAW  = 6;
    localparam int IW   = 22;
    localparam int MAXT = 600;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, src_re, dst_we;
    logic [PAW-1:0] imem_addr;
    logic [IW-1:0]  imem_data;
    logic [AW-1:0]  src_addr, dst_addr;
    logic [DW-1:0]  src_rdata, dst_wdata;

    logic [IW-1:0]  prog [0:(1<<PAW)-1];
    logic [DW-1:0]  smem [0:(1<<AW)-1];
    logic [AW-1:0]  mreg [0:15];
    bit             ew   [0:MAXT];
    logic [AW-1:0]  ewa  [0:MAXT];
    logic [DW-1:0]  ewd  [0:MAXT];
    int             halt_t;
    int             n_chk = 0;
    int             n_bad = 0;
    bit             finished = 0;

    always #10 clk = ~clk;

    xfer_engine #(.AW(AW), .DW(DW), .PAW(PAW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .src_re(src_re), .src_addr(src_addr), .src_rdata(src_rdata),
        .dst_we(dst_we), .dst_addr(dst_addr), .dst_wdata(dst_wdata)
    );

    assign imem_data = prog[imem_addr];

    always_ff @(posedge clk) if (src_re) src_rdata <= smem[src_addr];

    function automatic logic [IW-1:0] enc(int op, int a, int b, int c, int imm);
        return {op[1:0], a[3:0], b[3:0], c[3:0], imm[7:0]};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference interpreter built from the requirements (R3..R11)
    function automatic void build_expect();
        int pc = 0;
        int t  = 0;
        for (int i = 0; i <= MAXT; i++) ew[i] = 0;
        halt_t = MAXT - 4;
        while (t < MAXT - 4) begin
            logic [IW-1:0] w = prog[pc];
            int op  = int'(w[21:20]);
            int a   = int'(w[19:16]);
            int b   = int'(w[15:12]);
            int c   = int'(w[11:8]);
            int imm = int'(w[7:0]);
            if (op == 0) begin
                if (imm == 0) begin halt_t = t; break; end
                t++;
            end else if (op == 1) begin
                if (a != 0) mreg[a] = AW'(imm);
                t++;
            end else begin
                int k = (op == 2 || imm == 0) ? 1 : imm;
                for (int n = 0; n < k; n++) begin
                    logic [AW-1:0] off = (op == 2) ? AW'(imm) : AW'(n * int'(mreg[c]));
                    logic [AW-1:0] sa  = mreg[a] + off;
                    ew[t+1]  = 1;
                    ewa[t+1] = mreg[b] + off;
                    ewd[t+1] = smem[sa];
                    t++;
                end
            end
            pc = (pc + 1) % (1 << PAW);
        end
    endfunction

    task automatic run_prog();
        for (int i = 0; i < (1 << AW); i++) smem[i] = DW'($urandom);
        build_expect();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int t = 0; t <= halt_t + 4; t++) begin
            if (t == 0) check(done == 1'b0, "R10", "done after start", int'(done), 0);
            check(busy == (t <= halt_t), (t <= halt_t) ? "R2" : "R9", "busy", int'(busy), int'(t <= halt_t));
            check(done == (t > halt_t), "R9", "done", int'(done), int'(t > halt_t));
            check(dst_we == ew[t], "R5", "dst_we", int'(dst_we), int'(ew[t]));
            if (ew[t] && dst_we) begin
                check(dst_addr == ewa[t], "R6", "dst_addr", int'(dst_addr), int'(ewa[t]));
                check(dst_wdata == ewd[t], "R5", "dst_wdata", int'(dst_wdata), int'(ewd[t]));
            end
            if (t > halt_t) check(src_re == 1'b0, "R9", "src_re parked", int'(src_re), 0);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        for (int i = 0; i < (1 << PAW); i++) prog[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0 && done == 0, "R1", "busy|done in reset", int'(busy | done), 0);
        check(src_re == 0 && dst_we == 0, "R1", "re|we in reset", int'(src_re | dst_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0, "R1", "idle after reset", int'(busy | done), 0);

        // R9: immediate halt at instruction 0
        prog[0] = enc(0, 0, 0, 0, 0);
        run_prog();

        // R11 wrap, R6 block with stride, R4 load seen by next instruction
        prog[0] = enc(1, 1, 0, 0, 250);
        prog[1] = enc(1, 2, 0, 0, 200);
        prog[2] = enc(2, 1, 2, 0, 10);
        prog[3] = enc(1, 3, 0, 0, 100);
        prog[4] = enc(3, 2, 1, 3, 4);
        prog[5] = enc(0, 0, 0, 0, 0);
        run_prog();

        // R4 load into register 0 ignored, R7 count zero, R8 nonzero no-op
        prog[0] = enc(1, 0, 0, 0, 77);
        prog[1] = enc(2, 0, 0, 0, 5);
        prog[2] = enc(1, 4, 0, 0, 9);
        prog[3] = enc(3, 4, 0, 4, 0);
        prog[4] = enc(0, 0, 0, 0, 3);
        prog[5] = enc(0, 0, 0, 0, 200);
        prog[6] = enc(2, 4, 4, 0, 1);
        prog[7] = enc(0, 0, 0, 0, 0);
        run_prog();

        // Random programs (R3..R11), each run restarting from done (R10)
        for (int r = 0; r < 40; r++) begin
            int len = 6 + int'($urandom % 40);
            for (int i = 0; i < len; i++) begin
                int sel = int'($urandom % 10);
                int a = int'($urandom % 16);
                int b = int'($urandom % 16);
                int c = int'($urandom % 16);
                if (sel < 3 || sel == 9) prog[i] = enc(1, a, 0, 0, int'($urandom % 256));
                else if (sel < 6)        prog[i] = enc(2, a, b, 0, int'($urandom % 256));
                else if (sel < 8)        prog[i] = enc(3, a, b, c, int'($urandom % 7));
                else                     prog[i] = enc(0, 0, 0, 0, 1 + int'($urandom % 255));
            end
            prog[len] = enc(0, 0, 0, 0, 0);
            run_prog();
        end
        summary();
    end
endmodule